// File: doc/BRIEF.md
# Card Presence Filter and Interrupt

This block watches the mechanical switch of a smart-card socket and tells a host microcontroller when a card goes in or comes out. The switch pin and the host chip-select are both asynchronous, so each passes through a flop synchronizer before use. A level counter then filters the switch. Only a level that persists for a parameterised number of clock cycles becomes the accepted card state. Shorter bounces and spikes are discarded.

The switch can be of either kind, normally open or normally closed. A polarity bit, which the host may rewrite only while program mode is held active, selects how the pin level maps to card presence. Each accepted change in either direction pulls an active-low interrupt low. The interrupt stays low until the host acknowledges it. The host acknowledges with a rising chip-select edge that follows a low period of at least a minimum width, or by asking for card power, which is a rising power-on request while chip-select is low. When a card is removed, the block also emits a one-cycle power-down request to the supply sequencer. It does this whatever the power-on level is at the time.

Top module: `card_detect_irq`

## Requirements
- R1: While reset is held and after its release with the pin high, `irq_n` is 1, `card_present` is 0 and `pd_req` is 0; the polarity bit resets to 0 (normally open).
- R2: Polarity bit 0 (normally open) reports a card when the synchronized pin is low; polarity bit 1 (normally closed) reports a card when it is high. After a polarity write, `card_present` follows the new mapping exactly FILT_CYCLES clock edges after the write edge.
- R3: The polarity bit takes `pol_wd` only on a clock edge where `prog_n` is 0 and `pol_we` is 1; a write strobe with `prog_n` high has no effect on `card_present`.
- R4: A pin change reaches `card_present` exactly SYNC_STAGES+FILT_CYCLES clock edges after it is applied, and only after FILT_CYCLES consecutive synchronized cycles at the new level; a pulse shorter than FILT_CYCLES cycles changes neither `card_present` nor `irq_n`.
- R5: If the synchronized pin returns to the accepted level before the count expires, the count restarts from zero.
- R6: Every change of `card_present`, insertion or extraction, drives `irq_n` low on the following clock edge.
- R7: A rising synchronized chip-select that follows at least CS_MIN_CYCLES synchronized low cycles clears the interrupt one edge later (SYNC_STAGES+1 edges after the rise at the pin); a shorter low pulse has no effect.
- R8: A rising `pwr_on` while synchronized chip-select is low clears the interrupt on that edge; a rising `pwr_on` with chip-select high, or chip-select low alone, does not clear it.
- R9: When a new accepted change and a clear request fall on the same edge, the interrupt stays asserted.
- R10: Each accepted extraction raises `pd_req` for exactly one cycle, in the cycle where `card_present` falls, whatever the level of `pwr_on`.
- R11: Once asserted, `irq_n` stays low until a clear request from R7 or R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_pin | input | 1 | Raw socket switch level, asynchronous |
| cs_n | input | 1 | Host chip-select, active low, asynchronous |
| prog_n | input | 1 | Program mode, active low, synchronous |
| pol_we | input | 1 | Polarity write strobe, synchronous |
| pol_wd | input | 1 | Polarity value: 0 normally open, 1 normally closed |
| pwr_on | input | 1 | Host card-power request level, synchronous |
| irq_n | output | 1 | Active-low interrupt to the host |
| card_present | output | 1 | Filtered card-present flag |
| pd_req | output | 1 | One-cycle power-down request on extraction |

## Verification
On every cycle the assertions check that the accepted state moves only once the filter count has reached its limit, that each accepted change is followed by a low interrupt and the interrupt then holds until a clear request, that the interrupt rises only after a clear request, that the power-down pulse is a single cycle tied to a falling card flag, and that the polarity bit cannot move outside program mode. The exact latencies through the synchronizers, the rejection of every glitch width below the filter length, the rejection of every chip-select pulse below the minimum width, the restart of the count and the behaviour of both switch polarities are shown only by the bench's timed scenarios.

// File: rtl/cdi_pkg.sv
package cdi_pkg;

   typedef enum logic {
      POL_OPEN   = 1'b0,
      POL_CLOSED = 1'b1
   } sw_pol_e;

   // Map the synchronized pin level to "card is in the socket".
   // An open switch ties to ground on insertion (pin low);
   // a closed switch opens on insertion (pin high).
   function automatic logic card_level(sw_pol_e pol, logic pin);
      return (pol == POL_CLOSED) ? pin : ~pin;
   endfunction

endpackage

// File: rtl/cdi_sync.sv
module cdi_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cdi_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= RST_VAL;
            else        chain_q[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= RST_VAL;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/cdi_filter.sv
module cdi_filter #(
   parameter int LEN = 3750,
   localparam int CW = (LEN < 2) ? 1 : $clog2(LEN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lvl,
   output logic          state_o,
   output logic          rise_o,
   output logic          fall_o,
   output logic [CW-1:0] cnt_o
);

   if (LEN < 2) begin : g_bad_len
      $error("cdi_filter: LEN must be at least 2");
   end

   localparam logic [CW-1:0] LIM = CW'(LEN - 1);

   logic          state_q;
   logic          rise_q;
   logic          fall_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= 1'b0;
         cnt_q   <= '0;
         rise_q  <= 1'b0;
         fall_q  <= 1'b0;
      end else begin
         rise_q <= 1'b0;
         fall_q <= 1'b0;
         if (lvl == state_q) begin
            cnt_q <= '0;
         end else if (cnt_q == LIM) begin
            state_q <= lvl;
            cnt_q   <= '0;
            rise_q  <= lvl;
            fall_q  <= ~lvl;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign state_o = state_q;
   assign rise_o  = rise_q;
   assign fall_o  = fall_q;
   assign cnt_o   = cnt_q;

endmodule

// File: rtl/cdi_csqual.sv
module cdi_csqual #(
   parameter int MIN_LOW = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_s,
   output logic clr_o
);

   if (MIN_LOW < 1) begin : g_bad_min
      $error("cdi_csqual: MIN_LOW must be at least 1");
   end

   logic cs_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_d <= 1'b1;
      else        cs_d <= cs_s;
   end

   if (MIN_LOW <= 1) begin : g_edge_only
      // Any synchronized low cycle already meets the width.
      assign clr_o = cs_s & ~cs_d;
   end else begin : g_width_count
      localparam int            W   = $clog2(MIN_LOW + 1);
      localparam logic [W-1:0]  MIN = W'(MIN_LOW);

      logic [W-1:0] low_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             low_q <= '0;
         else if (cs_s)          low_q <= '0;
         else if (low_q != MIN)  low_q <= low_q + 1'b1;
      end

      assign clr_o = cs_s & ~cs_d & (low_q == MIN);
   end

endmodule

// File: rtl/card_detect_irq.sv
module card_detect_irq #(
   parameter int SYNC_STAGES   = 2,
   parameter int FILT_CYCLES   = 3750,
   parameter int CS_MIN_CYCLES = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic det_pin,
   input  logic cs_n,
   input  logic prog_n,
   input  logic pol_we,
   input  logic pol_wd,
   input  logic pwr_on,
   output logic irq_n,
   output logic card_present,
   output logic pd_req
);

   import cdi_pkg::*;

   localparam int FILT_CW = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("card_detect_irq: SYNC_STAGES must be at least 2");
   end
   if (FILT_CYCLES < 2) begin : g_bad_filt
      $error("card_detect_irq: FILT_CYCLES must be at least 2");
   end
   if (CS_MIN_CYCLES < 1) begin : g_bad_cs
      $error("card_detect_irq: CS_MIN_CYCLES must be at least 1");
   end

   sw_pol_e            pol_q;
   logic               det_s;
   logic               cs_s;
   logic               pwr_d;
   logic               pwr_rise;
   logic               cs_clr;
   logic               clr_any;
   logic               f_rise;
   logic               f_fall;
   logic               ev_any;
   logic               f_state;
   logic [FILT_CW-1:0] filt_cnt;
   logic               irq_q;

   cdi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_det_sync (
      .clk(clk), .rst_n(rst_n), .d(det_pin), .q(det_s)
   );

   cdi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
      .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s)
   );

   // Polarity register: writable only in program mode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pol_q <= POL_OPEN;
      else if (!prog_n && pol_we) pol_q <= sw_pol_e'(pol_wd);
   end

   cdi_filter #(.LEN(FILT_CYCLES)) u_filt (
      .clk(clk), .rst_n(rst_n),
      .lvl(card_level(pol_q, det_s)),
      .state_o(f_state), .rise_o(f_rise), .fall_o(f_fall), .cnt_o(filt_cnt)
   );

   cdi_csqual #(.MIN_LOW(CS_MIN_CYCLES)) u_csq (
      .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .clr_o(cs_clr)
   );

   // Power-up request edge, qualified by chip-select low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwr_d <= 1'b0;
      else        pwr_d <= pwr_on;
   end

   assign pwr_rise = pwr_on & ~pwr_d & ~cs_s;
   assign clr_any  = cs_clr | pwr_rise;
   assign ev_any   = f_rise | f_fall;

   // Interrupt latch: a new event takes priority over a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       irq_q <= 1'b0;
      else if (ev_any)  irq_q <= 1'b1;
      else if (clr_any) irq_q <= 1'b0;
   end

   assign irq_n        = ~irq_q;
   assign card_present = f_state;
   assign pd_req       = f_fall;

endmodule

// File: rtl/cdi_checker.sv
module cdi_checker #(
   parameter int FILT_CYCLES = 3750,
   parameter int CW          = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          irq_n,
   input logic          card_present,
   input logic          pd_req,
   input logic          prog_n,
   input logic          pol_q,
   input logic [CW-1:0] filt_cnt,
   input logic          filt_ev,
   input logic          clr_req
);

   localparam logic [CW-1:0] LIM = CW'(FILT_CYCLES - 1);

   // R4: accepted state moves only when the count has reached its limit
   assert_filter_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(card_present) |-> ($past(filt_cnt) == LIM));

   // R6: every accepted change is followed by a low interrupt
   assert_change_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(card_present) |=> !irq_n);

   // R9: a filter event always leaves the interrupt asserted, clear or not
   assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_ev && clr_req) |=> !irq_n);

   // R11: asserted interrupt holds without a clear request
   assert_irq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n && !clr_req) |=> !irq_n);

   // R7 / R8: the interrupt only rises after a clear request
   assert_clear_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_n) |-> $past(clr_req));

   // R10: power-down request coincides with a falling card flag
   assert_pd_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pd_req |-> (!card_present && $past(card_present)));

   // R10: power-down request lasts one cycle
   assert_pd_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pd_req |=> !pd_req);

   // R3: polarity cannot move outside program mode
   assert_pol_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      prog_n |=> $stable(pol_q));

endmodule

bind card_detect_irq cdi_checker #(
   .FILT_CYCLES(FILT_CYCLES),
   .CW(FILT_CW)
) u_chk (
   .clk(clk),
   .rst_n(rst_n),
   .irq_n(irq_n),
   .card_present(card_present),
   .pd_req(pd_req),
   .prog_n(prog_n),
   .pol_q(pol_q),
   .filt_cnt(filt_cnt),
   .filt_ev(ev_any),
   .clr_req(clr_any)
);

// File: tb/sim_card_detect_irq.sv
module sim_card_detect_irq;

   localparam int S = 2;
   localparam int F = 6;
   localparam int C = 4;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, det_pin, cs_n, prog_n, pol_we, pol_wd, pwr_on;
   logic irq_n, card_present, pd_req;

   int n_chk  = 0;
   int n_fail = 0;

   card_detect_irq #(
      .SYNC_STAGES(S), .FILT_CYCLES(F), .CS_MIN_CYCLES(C)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .det_pin(det_pin), .cs_n(cs_n),
      .prog_n(prog_n), .pol_we(pol_we), .pol_wd(pol_wd), .pwr_on(pwr_on),
      .irq_n(irq_n), .card_present(card_present), .pd_req(pd_req)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input string what,
                        input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic cs_ack;
      cs_n = 1'b0; tick(C); cs_n = 1'b1; tick(S + 2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      report();
   end

   initial begin
      rst_n = 1'b0; det_pin = 1'b1; cs_n = 1'b1; prog_n = 1'b1;
      pol_we = 1'b0; pol_wd = 1'b0; pwr_on = 1'b0;
      tick(4);
      check("R1", "irq_n in reset", irq_n, 1'b1);
      check("R1", "card_present in reset", card_present, 1'b0);
      check("R1", "pd_req in reset", pd_req, 1'b0);
      rst_n = 1'b1;
      tick(S + F + 5);
      check("R1", "open default, pin high, no card", card_present, 1'b0);
      check("R1", "irq_n idle", irq_n, 1'b1);

      // R4: every glitch width below the filter length is rejected
      for (int w = 1; w < F; w++) begin
         det_pin = 1'b0; tick(w); det_pin = 1'b1;
         tick(S + F + 3);
         check("R4", $sformatf("glitch %0d present", w), card_present, 1'b0);
         check("R4", $sformatf("glitch %0d irq", w), irq_n, 1'b1);
      end

      // R4 / R6: insertion with exact latency
      det_pin = 1'b0;
      tick(S + F - 1);
      check("R4", "present one edge early", card_present, 1'b0);
      tick(1);
      check("R4", "present on time", card_present, 1'b1);
      check("R6", "irq not yet", irq_n, 1'b1);
      tick(1);
      check("R6", "irq on insertion", irq_n, 1'b0);

      tick(40);
      check("R11", "irq held", irq_n, 1'b0);

      // R7: short chip-select pulses ignored
      for (int w = 1; w < C; w++) begin
         cs_n = 1'b0; tick(w); cs_n = 1'b1;
         tick(S + 3);
         check("R7", $sformatf("short cs %0d", w), irq_n, 1'b0);
      end
      cs_n = 1'b0; tick(C); cs_n = 1'b1;
      tick(S);
      check("R7", "clear one edge early", irq_n, 1'b0);
      tick(1);
      check("R7", "clear on time", irq_n, 1'b1);

      // R5: count restarts on return to the accepted level
      det_pin = 1'b1; tick(F - 1); det_pin = 1'b0; tick(1);
      det_pin = 1'b1; tick(F - 1); det_pin = 1'b0;
      tick(S + F + 3);
      check("R5", "split removal keeps card", card_present, 1'b1);
      check("R5", "split removal no irq", irq_n, 1'b1);

      // R10 / R6: extraction with power request low
      det_pin = 1'b1;
      tick(S + F);
      check("R10", "pd_req on extraction", pd_req, 1'b1);
      check("R6", "card gone", card_present, 1'b0);
      tick(1);
      check("R10", "pd_req one cycle", pd_req, 1'b0);
      check("R6", "irq on extraction", irq_n, 1'b0);

      // R8: power rise with chip-select high does not clear
      pwr_on = 1'b1; tick(3);
      check("R8", "pwr rise with cs high", irq_n, 1'b0);

      // R9: insertion event and cs clear on the same edge
      pwr_on = 1'b0;
      det_pin = 1'b0; cs_n = 1'b0;
      tick(F);
      cs_n = 1'b1;
      tick(S);
      check("R9", "card accepted", card_present, 1'b1);
      tick(1);
      check("R9", "event beats clear", irq_n, 1'b0);
      tick(3);
      check("R9", "still asserted", irq_n, 1'b0);

      // R8: power-up request with chip-select low clears
      cs_n = 1'b0; tick(S + 2);
      check("R8", "cs low alone", irq_n, 1'b0);
      pwr_on = 1'b1; tick(1);
      check("R8", "pwr rise with cs low", irq_n, 1'b1);
      cs_n = 1'b1; tick(S + 3);

      // R10: extraction with power request high
      det_pin = 1'b1;
      tick(S + F);
      check("R10", "pd_req with pwr_on high", pd_req, 1'b1);
      tick(1);
      check("R10", "pd_req ends", pd_req, 1'b0);
      pwr_on = 1'b0;
      cs_ack();
      check("R7", "ack after extraction", irq_n, 1'b1);

      // R3: write strobe outside program mode ignored
      prog_n = 1'b1; pol_we = 1'b1; pol_wd = 1'b1; tick(1); pol_we = 1'b0;
      tick(S + F + 4);
      check("R3", "locked polarity, no card", card_present, 1'b0);
      check("R3", "locked polarity, no irq", irq_n, 1'b1);

      // R2: closed polarity, pin high means card
      prog_n = 1'b0; pol_we = 1'b1; pol_wd = 1'b1; tick(1);
      pol_we = 1'b0; prog_n = 1'b1;
      tick(F - 1);
      check("R2", "closed mapping early", card_present, 1'b0);
      tick(1);
      check("R2", "closed mapping, pin high = card", card_present, 1'b1);
      tick(1);
      check("R6", "irq after polarity change", irq_n, 1'b0);
      cs_ack();
      det_pin = 1'b0;
      tick(S + F - 1);
      check("R2", "closed removal early", card_present, 1'b1);
      tick(1);
      check("R2", "closed mapping, pin low = no card", card_present, 1'b0);
      check("R10", "pd_req closed removal", pd_req, 1'b1);

      tick(5);
      report();
   end

endmodule